// File: doc/BRIEF.md
# Selectable Baud Rate Tick Generator

This block turns one fast system clock into two streams of one-cycle enable pulses for a serial link. One stream runs at sixteen times the bit rate and drives an oversampling receiver or transmitter. The other runs at the bit rate itself. The clock passes through a fixed integer prescaler, which divides by 3 by default. A programmable integer divider follows it and sets the oversample tick period. A divide-by-16 counter on the oversample ticks then produces the bit tick.

A 3-bit rate code selects one of seven standard bit rates. The divisors for these rates are computed at elaboration from the clock frequency and the prescaler ratio, and each is rounded to the nearest integer. The eighth code uses a divisor driven directly on an input port. A new code or divisor takes effect only when the running interval completes, so a rate change never produces a short interval. A synchronous phase-clear input restarts the prescaler and both tick counters so that tick timing can be aligned to an external event.

Top module: `baud_tick_gen`

## Requirements
- R1: The interval between consecutive oversample ticks is exactly PRE_DIV × D system clock cycles, where D is the effective divisor.
- R2: Rate codes 0 to 6 select the bit rates 460800, 230400, 115200, 57600, 38400, 19200 and 9600. Each code uses the divisor round(CLK_HZ / (PRE_DIV·16·rate)). With the default parameters these divisors are 1, 2, 4, 8, 12, 24 and 48, and the divisor input is ignored.
- R3: Rate code 7 uses the divisor input as D. A divisor input of 0 acts as 1, which gives one oversample tick per prescaler period.
- R4: Each tick output is high for exactly one clock cycle per event.
- R5: The bit tick is high only together with an oversample tick. It marks the 16th, 32nd, and each later 16th oversample tick, counted from reset or from phase clear.
- R6: A change of rate code or divisor does not alter the interval in progress. The new divisor applies from the next terminal count.
- R7: While phase clear is high, both tick outputs stay low. Releasing it restarts the tick sequence from the beginning.
- R8: While reset is asserted, both tick outputs are low. Reset is applied asynchronously and released synchronously to the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| phase_clr_i | input | 1 | Synchronous restart of the prescaler and both tick counters |
| rate_sel_i | input | 3 | Rate code: 0 to 6 select standard rates, 7 selects the divisor input |
| div_i | input | DIV_W | Divisor used when the rate code is 7 |
| tick_ovs_o | output | 1 | One-cycle tick at 16 times the bit rate |
| tick_bit_o | output | 1 | One-cycle tick at the bit rate |

## Verification
If the prescaler or divider counter is wrong, the spacing of the oversample ticks changes. The error appears at the first tick after the fault, so it shows up within one interval of at most PRE_DIV × D cycles. If the divide-by-16 counter slips, the bit tick moves to a different oversample tick. That error takes up to sixteen oversample intervals to show. Counting the oversample ticks from a phase clear to the first bit tick exposes it. If the reload happens at the wrong time, either a short interval appears right after a rate change or the old rate continues for one interval too many. Measuring the two intervals that follow a rate change exposes either case.

// File: rtl/baud_tick_pkg.sv
`timescale 1ns/1ps
package baud_tick_pkg;

  typedef enum logic [2:0] {
    RATE_460K8  = 3'd0,
    RATE_230K4  = 3'd1,
    RATE_115K2  = 3'd2,
    RATE_57K6   = 3'd3,
    RATE_38K4   = 3'd4,
    RATE_19K2   = 3'd5,
    RATE_9K6    = 3'd6,
    RATE_LOADED = 3'd7
  } rate_sel_e;

  localparam int unsigned NUM_FIXED_RATES = 7;

  // Nominal bit rate for each fixed code; the loaded code has no rate.
  function automatic longint unsigned nominal_rate(input int unsigned idx);
    case (idx)
      0: return 64'd460800;
      1: return 64'd230400;
      2: return 64'd115200;
      3: return 64'd57600;
      4: return 64'd38400;
      5: return 64'd19200;
      6: return 64'd9600;
      default: return 64'd1;
    endcase
  endfunction

  // Integer division rounded to nearest.
  function automatic longint unsigned round_div(input longint unsigned num,
                                                input longint unsigned den);
    return (num + den / 2) / den;
  endfunction

  // Clamp a divisor into [1, max_val].
  function automatic longint unsigned clamp_div(input longint unsigned raw,
                                                input longint unsigned max_val);
    if (raw < 1) return 64'd1;
    if (raw > max_val) return max_val;
    return raw;
  endfunction

endpackage

// File: rtl/baud_prescaler.sv
`timescale 1ns/1ps
module baud_prescaler #(
  parameter int unsigned PRE_DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic en_o
);

  localparam int unsigned CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

  logic [CW-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign en_o = (cnt_q == LAST) && !clr_i;

  // Enable pulses are separated by at least one idle cycle when the ratio exceeds one.
  AST_PRE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && (PRE_DIV > 1)) |=> !en_o); // R1

endmodule

// File: rtl/baud_div_select.sv
`timescale 1ns/1ps
module baud_div_select
  import baud_tick_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 64'd22118400,
  parameter int unsigned     PRE_DIV = 3,
  parameter int unsigned     OVS     = 16,
  parameter int unsigned     DIV_W   = 16
) (
  input  logic [2:0]       rate_sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] eff_div_o
);

  localparam longint unsigned DIV_MAX = (64'd1 << DIV_W) - 64'd1;

  logic [DIV_W-1:0] table_div [0:7];

  for (genvar g = 0; g < 8; g++) begin : g_table
    if (g < NUM_FIXED_RATES) begin : g_fixed
      localparam longint unsigned DEN =
        longint'(PRE_DIV) * longint'(OVS) * nominal_rate(g);
      localparam longint unsigned RAW = round_div(CLK_HZ, DEN);
      localparam longint unsigned SAT = clamp_div(RAW, DIV_MAX);
      assign table_div[g] = SAT[DIV_W-1:0];
    end else begin : g_loaded_slot
      assign table_div[g] = '0;
    end
  end

  always_comb begin
    if (rate_sel_e'(rate_sel_i) == RATE_LOADED) begin
      eff_div_o = (div_i == '0) ? DIV_W'(1) : div_i;
    end else begin
      eff_div_o = table_div[rate_sel_i];
    end
  end

endmodule

// File: rtl/baud_tick_divider.sv
`timescale 1ns/1ps
module baud_tick_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             pre_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             fire_o,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_d, cnt_q;
  logic             tick_d, tick_q;

  assign fire_o = pre_en_i && (cnt_q == '0) && !clr_i;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (fire_o) begin
      cnt_d  = div_i - 1'b1;
      tick_d = 1'b1;
    end else if (pre_en_i) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // Mid-interval the counter only holds or steps down; no early reload.
  AST_NO_RUNT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q != '0) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1)); // R6
  // A tick cannot repeat unless the prescaler enabled the cycle that follows it.
  AST_TICK_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !pre_en_i) |=> !tick_o); // R4
  // Phase clear silences the next tick.
  AST_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tick_o); // R7

endmodule

// File: rtl/baud_bit_counter.sv
`timescale 1ns/1ps
module baud_bit_counter #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic fire_i,
  output logic bit_tick_o
);

  localparam int unsigned    BW   = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [BW-1:0]  LAST = BW'(OVS - 1);

  logic [BW-1:0] bcnt_d, bcnt_q;
  logic          bit_d, bit_q;

  always_comb begin
    bcnt_d = bcnt_q;
    bit_d  = 1'b0;
    if (clr_i) begin
      bcnt_d = '0;
    end else if (fire_i) begin
      if (bcnt_q == LAST) begin
        bcnt_d = '0;
        bit_d  = 1'b1;
      end else begin
        bcnt_d = bcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q <= '0;
      bit_q  <= 1'b0;
    end else begin
      bcnt_q <= bcnt_d;
      bit_q  <= bit_d;
    end
  end

  assign bit_tick_o = bit_q;

  // A bit tick always leaves the oversample count at the start of a bit.
  AST_BIT_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> (bcnt_q == '0)); // R5

endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen #(
  parameter longint unsigned CLK_HZ  = 64'd22118400,
  parameter int unsigned     PRE_DIV = 3,
  parameter int unsigned     OVS     = 16,
  parameter int unsigned     DIV_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             phase_clr_i,
  input  logic [2:0]       rate_sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_ovs_o,
  output logic             tick_bit_o
);

  logic rst_meta_q, rst_sync_nq;
  logic pre_en;
  logic fire;
  logic [DIV_W-1:0] eff_div;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q  <= 1'b0;
      rst_sync_nq <= 1'b0;
    end else begin
      rst_meta_q  <= 1'b1;
      rst_sync_nq <= rst_meta_q;
    end
  end

  baud_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_nq),
    .clr_i  (phase_clr_i),
    .en_o   (pre_en)
  );

  baud_div_select #(
    .CLK_HZ (CLK_HZ),
    .PRE_DIV(PRE_DIV),
    .OVS    (OVS),
    .DIV_W  (DIV_W)
  ) u_sel (
    .rate_sel_i(rate_sel_i),
    .div_i     (div_i),
    .eff_div_o (eff_div)
  );

  baud_tick_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_nq),
    .clr_i   (phase_clr_i),
    .pre_en_i(pre_en),
    .div_i   (eff_div),
    .fire_o  (fire),
    .tick_o  (tick_ovs_o)
  );

  baud_bit_counter #(.OVS(OVS)) u_bit (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_nq),
    .clr_i     (phase_clr_i),
    .fire_i    (fire),
    .bit_tick_o(tick_bit_o)
  );

  // Bit tick only ever rides on an oversample tick.
  AST_BIT_ON_OVS: assert property (@(posedge clk_i) disable iff (!rst_sync_nq)
    tick_bit_o |-> tick_ovs_o); // R5
  // Divisor fed to the counter is never zero.
  AST_DIV_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_sync_nq)
    fire |=> (tick_ovs_o && eff_div != '0)); // R3

endmodule

// File: tb/baud_tick_gen_tb.sv
`timescale 1ns/1ps
module baud_tick_gen_tb;

  localparam int unsigned DIV_W = 16;
  localparam int unsigned NV    = 11;
  // rate code, divisor input, expected oversample period (cycles)
  localparam int unsigned V_SEL [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 7, 7, 7};
  localparam int unsigned V_DIV [NV] = '{999, 7, 0, 3, 0, 0, 0, 5, 0, 1, 1000};
  localparam int unsigned V_PER [NV] = '{3, 6, 12, 24, 36, 72, 144, 15, 3, 3, 3000};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clr = 1'b0;
  logic [2:0]       sel = 3'd0;
  logic [DIV_W-1:0] div = '0;
  logic             tick_ovs, tick_bit;

  int n_chk = 0;
  int n_fail = 0;
  int stray = 0;

  always #2 clk = ~clk;

  baud_tick_gen #(.DIV_W(DIV_W)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .phase_clr_i(clr),
    .rate_sel_i (sel),
    .div_i      (div),
    .tick_ovs_o (tick_ovs),
    .tick_bit_o (tick_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_ovs();
    do @(negedge clk); while (tick_ovs !== 1'b1);
  endtask

  task automatic gap_ovs(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
      if (tick_bit === 1'b1 && tick_ovs !== 1'b1) stray++;
    end while (tick_ovs !== 1'b1);
  endtask

  task automatic gap_bit(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (tick_bit !== 1'b1);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic count_to_bit(output int n);
    n = 0;
    do begin
      @(negedge clk);
      if (tick_ovs === 1'b1) n++;
    end while (tick_bit !== 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int g, g2, n;
    // R8: outputs low under reset
    repeat (5) @(negedge clk);
    check(tick_ovs === 1'b0 && tick_bit === 1'b0, "R8 reset outputs", int'(tick_ovs), 0);
    rst_n = 1'b1;

    // R5: from reset, bit tick lands on 16th oversample tick (code 1, period 6)
    @(negedge clk); sel = 3'd1; div = '0;
    count_to_bit(n);
    check(n == 16, "R5 bit tick after reset", n, 16);

    // R1/R2/R3: table of rate codes
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sel = V_SEL[i][2:0];
      div = V_DIV[i][DIV_W-1:0];
      pulse_clr();
      next_ovs();
      @(negedge clk);
      check(tick_ovs === 1'b0, "R4 ovs tick one cycle wide", int'(tick_ovs), 0);
      next_ovs();
      gap_ovs(g);
      gap_ovs(g2);
      check(g == int'(V_PER[i]) && g2 == int'(V_PER[i]),
            (V_SEL[i] == 7) ? "R3 loaded divisor period" : "R2 R1 rate code period",
            g, int'(V_PER[i]));
    end
    check(stray == 0, "R5 bit tick without ovs tick", stray, 0);

    // R5: bit period and alignment after phase clear at 9600
    @(negedge clk); sel = 3'd6; div = '0;
    pulse_clr();
    count_to_bit(n);
    check(n == 16, "R5 bit tick after phase clear", n, 16);
    @(negedge clk);
    check(tick_bit === 1'b0, "R4 bit tick one cycle wide", int'(tick_bit), 0);
    gap_bit(g);
    check(g == 2303, "R5 bit period at 9600", g + 1, 2304);

    // R6: change mid-interval keeps current interval
    next_ovs();
    repeat (10) @(negedge clk);
    sel = 3'd0;
    gap_ovs(g);
    check(g == 134, "R6 interval after change", g + 10, 144);
    gap_ovs(g);
    check(g == 3, "R6 new rate applied", g, 3);

    // R7: no ticks while phase clear held
    @(negedge clk); clr = 1'b1;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k > 0 && (tick_ovs === 1'b1 || tick_bit === 1'b1)) n++;
    end
    check(n == 0, "R7 quiet during clear", n, 0);
    clr = 1'b0;
    count_to_bit(n);
    check(n == 16, "R7 restart after clear", n, 16);

    // R8: asynchronous reset mid-run
    @(negedge clk); sel = 3'd7; div = 16'd1;
    repeat (7) @(negedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    check(tick_ovs === 1'b0 && tick_bit === 1'b0, "R8 mid-run reset", int'(tick_ovs), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    count_to_bit(n);
    check(n == 16, "R8 R5 restart after reset", n, 16);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule